// File: doc/BRIEF.md
# Answer-to-Reset Window Monitor

This block supervises the answer-to-reset phase of a contact smart card session. Once the card clock is running and the card reset line is held low, it counts card clocks and watches the card data line for the first start bit, which is the first high-to-low transition of the synchronised line. It decides when to release the card reset line. It classifies the first answer against fixed clock-count windows, and it raises an early flag or a mute flag when the card answers outside those windows.

There are two phases. In the reset-low phase the reset line is held low. An answer in this phase after an initial blanking interval marks the card as both early and mute, and the reset line then stays low so that software can decide what to do with the card. With no answer, the reset line goes high after a full window and the count starts again. In the reset-high phase a very early answer sets the early flag. An answer inside the window ends the count, and the card is then ready for commands. A card that stays silent for a whole window is marked mute, and a warm reset begins automatically. The host can also request a warm reset at any time during a session. A warm reset pulls the reset line low for a full window and then applies the reset-high rules again. The flags hold until the status is read, which arrives as a clear pulse.

Top module: `atr_window_monitor`

## Requirements
- R1: While `sessionEn` is low, `cardRst` and `atrDone` are low one cycle later. When `sessionEn` goes high, a cold sequence starts with `cardRst` low and the clock count at zero.
- R2: The count advances only on cycles with `clkEn` high. With no answer, `cardRst` goes high on the edge that completes `WINDOW_CLKS` counted clocks, and the count restarts from zero.
- R3: In the reset-low phase, a start bit whose count is below `IGNORE_CLKS` is ignored: no flag is set, and `cardRst` still rises at the end of the window.
- R4: In the reset-low phase, a start bit whose count is from `IGNORE_CLKS` to `WINDOW_CLKS-1` sets both `earlyFlag` and `muteFlag` and raises `atrDone`, and `cardRst` stays low.
- R5: In the reset-high phase, a start bit whose count is below `EARLY_CLKS` sets `earlyFlag` and raises `atrDone`, with `cardRst` staying high.
- R6: In the reset-high phase, a start bit whose count is from `EARLY_CLKS` to `WINDOW_CLKS-1` raises `atrDone` and sets no flag. A start bit that coincides with the last counted clock still counts as an answer.
- R7: With no start bit within `WINDOW_CLKS` counted clocks after `cardRst` rises, `muteFlag` is set, `warmPulse` is high for one cycle, and `cardRst` goes low. After a further `WINDOW_CLKS` counted clocks, `cardRst` goes high again.
- R8: A one-cycle `warmReq` during an active session pulls `cardRst` low, pulses `warmPulse`, clears `atrDone` and starts a new reset-low phase. That phase is followed by the reset-high rules of R5 to R7.
- R9: `earlyFlag` and `muteFlag` stay set, across session changes and warm resets, until a `flagClr` pulse. The pulse clears them on the next edge.
- R10: A start bit is a high-to-low change of `ioLevel` (1 = line high) after the two-stage synchroniser. A line that is already low when the session starts, and stays low, is not an answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sessionEn | input | 1 | High for the duration of a card session |
| warmReq | input | 1 | One-cycle host request for a warm reset |
| clkEn | input | 1 | High on cycles that carry one card clock |
| ioLevel | input | 1 | Card data line level, 1 = high |
| flagClr | input | 1 | One-cycle clear of both flags (status read) |
| cardRst | output | 1 | Reset level driven to the card |
| earlyFlag | output | 1 | Answer arrived too early |
| muteFlag | output | 1 | Answer missing or arrived in the reset-low phase |
| warmPulse | output | 1 | One-cycle strobe when a warm reset begins |
| atrDone | output | 1 | First answer accepted, count stopped |

## Verification
A change on `ioLevel` driven just after edge A passes two synchroniser edges. The resulting start bit is judged on edge A+3 against the count that edge A+2 left behind, so flags and `atrDone` are sampled just after edge A+3. `cardRst` rises, and `warmPulse` rises with mute, on the edge that completes the window. The host inputs `warmReq`, `sessionEn` and `flagClr` take effect on the first edge after they are driven. The bench numbers every edge from the start of the session and drives and samples one time unit after the computed edge. This places every window boundary, both one clock inside it and exactly on it, on a known cycle.

// File: rtl/atr_mon_pkg.sv
package atr_mon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLOW,
    ST_RSTHIGH,
    ST_ANSWERED,
    ST_HELD
  } atrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic rstSet;
    logic rstClr;
    logic earlySet;
    logic muteSet;
  } atrStrobe_t;

  // window comparisons from datapath to control
  typedef struct packed {
    logic pastIgnore;
    logic inEarly;
    logic windowEnd;
  } atrStatus_t;

endpackage

// File: rtl/atr_io_edge.sv
module atr_io_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ioLevel,
  output logic fallSeen
);

  // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[SYNC_STAGES-1:0], ioLevel};
  end

  assign fallSeen = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

endmodule

// File: rtl/atr_datapath.sv
module atr_datapath
  import atr_mon_pkg::*;
#(
  parameter int IGNORE_CLKS = 200,
  parameter int EARLY_CLKS  = 370,
  parameter int WINDOW_CLKS = 42100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       flagClr,
  input  atrStrobe_t stb,
  output atrStatus_t status,
  output logic       rstLevel,
  output logic       earlyQ,
  output logic       muteQ
);

  localparam int CW = $clog2(WINDOW_CLKS + 1);
  localparam logic [CW-1:0] IGN_C  = CW'(IGNORE_CLKS);
  localparam logic [CW-1:0] ERL_C  = CW'(EARLY_CLKS);
  localparam logic [CW-1:0] LAST_C = CW'(WINDOW_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (stb.cntClr)          cnt <= '0;
    else if (stb.cntRun && clkEn) cnt <= cnt + 1'b1;
  end

  always_comb begin
    status.pastIgnore = (cnt >= IGN_C);
    status.inEarly    = (cnt < ERL_C);
    status.windowEnd  = (cnt == LAST_C) && clkEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rstLevel <= 1'b0;
    else if (stb.rstClr) rstLevel <= 1'b0;
    else if (stb.rstSet) rstLevel <= 1'b1;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyQ <= 1'b0;
      muteQ  <= 1'b0;
    end else begin
      if (stb.earlySet)   earlyQ <= 1'b1;
      else if (flagClr)   earlyQ <= 1'b0;
      if (stb.muteSet)    muteQ  <= 1'b1;
      else if (flagClr)   muteQ  <= 1'b0;
    end
  end

endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sessionEn,
  input  logic       warmReq,
  input  logic       fallSeen,
  input  atrStatus_t status,
  output atrStrobe_t stb,
  output logic       doneOut,
  output logic       warmOut
);

  atrState_t stQ, stNext;
  logic      warmNext;

  always_comb begin
    stNext     = stQ;
    stb        = '0;
    warmNext   = 1'b0;
    stb.cntRun = (stQ == ST_RSTLOW) || (stQ == ST_RSTHIGH);
    if (!sessionEn) begin
      stNext     = ST_IDLE;
      stb.cntClr = 1'b1;
      stb.rstClr = 1'b1;
    end else if (warmReq && (stQ != ST_IDLE)) begin
      stNext     = ST_RSTLOW;
      stb.cntClr = 1'b1;
      stb.rstClr = 1'b1;
      warmNext   = 1'b1;
    end else begin
      case (stQ)
        ST_IDLE: begin
          stNext     = ST_RSTLOW;
          stb.cntClr = 1'b1;
          stb.rstClr = 1'b1;
        end
        ST_RSTLOW: begin
          if (fallSeen && status.pastIgnore) begin
            stb.earlySet = 1'b1;
            stb.muteSet  = 1'b1;
            stNext       = ST_HELD;
          end else if (status.windowEnd) begin
            stb.cntClr = 1'b1;
            stb.rstSet = 1'b1;
            stNext     = ST_RSTHIGH;
          end
        end
        ST_RSTHIGH: begin
          if (fallSeen) begin
            stb.earlySet = status.inEarly;
            stNext       = ST_ANSWERED;
          end else if (status.windowEnd) begin
            stb.muteSet = 1'b1;
            stb.cntClr  = 1'b1;
            stb.rstClr  = 1'b1;
            warmNext    = 1'b1;
            stNext      = ST_RSTLOW;
          end
        end
        ST_ANSWERED, ST_HELD: stNext = stQ;
        default:              stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= ST_IDLE;
      warmOut <= 1'b0;
    end else begin
      stQ     <= stNext;
      warmOut <= warmNext;
    end
  end

  assign doneOut = (stQ == ST_ANSWERED) || (stQ == ST_HELD);

endmodule

// File: rtl/atr_window_monitor.sv
module atr_window_monitor
  import atr_mon_pkg::*;
#(
  parameter int IGNORE_CLKS = 200,
  parameter int EARLY_CLKS  = 370,
  parameter int WINDOW_CLKS = 42100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sessionEn,
  input  logic warmReq,
  input  logic clkEn,
  input  logic ioLevel,
  input  logic flagClr,
  output logic cardRst,
  output logic earlyFlag,
  output logic muteFlag,
  output logic warmPulse,
  output logic atrDone
);

  atrStrobe_t stb;
  atrStatus_t status;
  logic       fallSeen;

  atr_io_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk      (clk),
    .rstN     (rstN),
    .ioLevel  (ioLevel),
    .fallSeen (fallSeen)
  );

  atr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sessionEn (sessionEn),
    .warmReq   (warmReq),
    .fallSeen  (fallSeen),
    .status    (status),
    .stb       (stb),
    .doneOut   (atrDone),
    .warmOut   (warmPulse)
  );

  atr_datapath #(
    .IGNORE_CLKS (IGNORE_CLKS),
    .EARLY_CLKS  (EARLY_CLKS),
    .WINDOW_CLKS (WINDOW_CLKS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .flagClr  (flagClr),
    .stb      (stb),
    .status   (status),
    .rstLevel (cardRst),
    .earlyQ   (earlyFlag),
    .muteQ    (muteFlag)
  );

endmodule

// File: rtl/atr_window_monitor_chk.sv
module atr_window_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic sessionEn,
  input logic warmReq,
  input logic flagClr,
  input logic cardRst,
  input logic earlyFlag,
  input logic muteFlag,
  input logic warmPulse,
  input logic atrDone
);

  assert_session_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !sessionEn |=> (!cardRst && !atrDone));

  assert_rst_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardRst) |-> ($past(sessionEn) && !atrDone && !warmPulse));

  assert_low_answer_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(atrDone) && !cardRst) |-> (earlyFlag && muteFlag));

  assert_answer_keeps_rst_R5: assert property (@(posedge clk) disable iff (!rstN)
    (atrDone && cardRst && sessionEn && !warmReq) |=> (cardRst && atrDone));

  assert_warm_drops_rst_R7: assert property (@(posedge clk) disable iff (!rstN)
    warmPulse |-> (!cardRst && !atrDone));

  assert_warm_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (warmPulse && !warmReq) |=> !warmPulse);

  assert_early_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(earlyFlag) |-> $past(flagClr));

  assert_mute_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(muteFlag) |-> $past(flagClr));

endmodule

bind atr_window_monitor atr_window_monitor_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sessionEn (sessionEn),
  .warmReq   (warmReq),
  .flagClr   (flagClr),
  .cardRst   (cardRst),
  .earlyFlag (earlyFlag),
  .muteFlag  (muteFlag),
  .warmPulse (warmPulse),
  .atrDone   (atrDone)
);

// File: tb/atr_window_monitor_tb_top.sv
module atr_window_monitor_tb_top;

  localparam int CLK_P = 10;
  localparam int IGN = 20;
  localparam int ERL = 37;
  localparam int WIN = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sessionEn = 1'b0, warmReq = 1'b0, clkEn = 1'b1, ioLevel = 1'b1, flagClr = 1'b0;
  logic cardRst, earlyFlag, muteFlag, warmPulse, atrDone;

  int edgeCnt = 0;
  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  atr_window_monitor #(
    .IGNORE_CLKS (IGN),
    .EARLY_CLKS  (ERL),
    .WINDOW_CLKS (WIN)
  ) dut_i (
    .clk (clk), .rstN (rstN), .sessionEn (sessionEn), .warmReq (warmReq),
    .clkEn (clkEn), .ioLevel (ioLevel), .flagClr (flagClr),
    .cardRst (cardRst), .earlyFlag (earlyFlag), .muteFlag (muteFlag),
    .warmPulse (warmPulse), .atrDone (atrDone)
  );

  typedef struct packed {
    logic        hiPhase;
    logic [15:0] ansCnt;
    logic        expEarly;
    logic        expMute;
    logic        expDone;
    logic        expRst;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'd5,   1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd19,  1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd20,  1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b0, 16'd399, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 16'd5,   1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 16'd36,  1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 16'd37,  1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 16'd399, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0b expected=%0b (edge %0d)", tag, what, act, exp, edgeCnt);
    end
  endtask

  // returns one time unit after edge n
  task automatic waitEdge(input int n);
    while (edgeCnt < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // returns the edge number on which the cold sequence starts
  task automatic startSession(output int e0, input logic ioInit);
    sessionEn = 1'b0;
    flagClr   = 1'b1;
    ioLevel   = ioInit;
    warmReq   = 1'b0;
    waitEdge(edgeCnt + 2);
    flagClr = 1'b0;
    waitEdge(edgeCnt + 4);
    sessionEn = 1'b1;
    e0 = edgeCnt + 1;
  endtask

  initial begin
    int e0, e1, e2, n, c, base, hits;
    string tag;
    // reset state
    #(CLK_P*3 + 1);
    chk("R1", "reset cardRst", cardRst, 1'b0);
    chk("R9", "reset earlyFlag", earlyFlag, 1'b0);
    chk("R9", "reset muteFlag", muteFlag, 1'b0);
    chk("R1", "reset atrDone", atrDone, 1'b0);
    chk("R7", "reset warmPulse", warmPulse, 1'b0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // table of window cases
    for (int i = 0; i < 8; i++) begin
      startSession(e0, 1'b1);
      base = VECS[i].hiPhase ? e0 + WIN : e0;
      c    = int'(VECS[i].ansCnt);
      tag  = VECS[i].hiPhase ? (VECS[i].expEarly ? "R5" : "R6")
                             : (VECS[i].expMute ? "R4" : "R3");
      waitEdge(base + c - 2);
      ioLevel = 1'b0;
      waitEdge(base + c + 1);
      chk(tag, "earlyFlag", earlyFlag, VECS[i].expEarly);
      chk(tag, "muteFlag", muteFlag, VECS[i].expMute);
      chk(tag, "atrDone", atrDone, VECS[i].expDone);
      chk(tag, "cardRst", cardRst, VECS[i].expRst);
      ioLevel = 1'b1;
      if (!VECS[i].hiPhase && !VECS[i].expMute) begin
        waitEdge(e0 + WIN + 1);
        chk("R3", "cardRst after ignored answer", cardRst, 1'b1);
        chk("R3", "no flag after ignored answer", earlyFlag | muteFlag, 1'b0);
      end
    end

    // R2 exact window edge and R7 mute timeout with automatic warm reset
    startSession(e0, 1'b1);
    waitEdge(e0 + WIN - 1);
    chk("R2", "cardRst one clock before window end", cardRst, 1'b0);
    waitEdge(e0 + WIN);
    chk("R2", "cardRst at window end", cardRst, 1'b1);
    e1 = e0 + WIN;
    waitEdge(e1 + WIN - 1);
    chk("R7", "muteFlag before timeout", muteFlag, 1'b0);
    waitEdge(e1 + WIN);
    chk("R7", "muteFlag at timeout", muteFlag, 1'b1);
    chk("R7", "warmPulse at timeout", warmPulse, 1'b1);
    chk("R7", "cardRst low at timeout", cardRst, 1'b0);
    chk("R7", "earlyFlag at timeout", earlyFlag, 1'b0);
    waitEdge(e1 + WIN + 1);
    chk("R7", "warmPulse single cycle", warmPulse, 1'b0);
    e2 = e1 + 2*WIN;
    waitEdge(e2 - 1);
    chk("R7", "cardRst low during warm phase", cardRst, 1'b0);
    waitEdge(e2);
    chk("R7", "cardRst high after warm phase", cardRst, 1'b1);
    waitEdge(e2 + 38);
    ioLevel = 1'b0;
    waitEdge(e2 + 41);
    chk("R7", "answer after warm reset", atrDone, 1'b1);
    chk("R9", "muteFlag held", muteFlag, 1'b1);
    ioLevel = 1'b1;
    n = edgeCnt;
    flagClr = 1'b1;
    waitEdge(n + 1);
    flagClr = 1'b0;
    waitEdge(n + 2);
    chk("R9", "muteFlag cleared by flagClr", muteFlag, 1'b0);
    chk("R9", "atrDone unaffected by flagClr", atrDone, 1'b1);

    // R8 host warm reset from the answered state
    n = edgeCnt;
    warmReq = 1'b1;
    waitEdge(n + 1);
    warmReq = 1'b0;
    chk("R8", "cardRst low on warmReq", cardRst, 1'b0);
    chk("R8", "warmPulse on warmReq", warmPulse, 1'b1);
    chk("R8", "atrDone cleared on warmReq", atrDone, 1'b0);
    e0 = n + 1;
    waitEdge(e0 + WIN - 1);
    chk("R8", "cardRst low before window end", cardRst, 1'b0);
    waitEdge(e0 + WIN);
    chk("R8", "cardRst high after window", cardRst, 1'b1);
    waitEdge(e0 + WIN + 8);
    ioLevel = 1'b0;
    waitEdge(e0 + WIN + 11);
    chk("R8", "early answer after warm reset", earlyFlag, 1'b1);
    chk("R8", "atrDone after warm reset", atrDone, 1'b1);
    ioLevel = 1'b1;

    // R1 session end with reset high
    n = edgeCnt;
    sessionEn = 1'b0;
    waitEdge(n + 1);
    chk("R1", "cardRst after session end", cardRst, 1'b0);
    chk("R1", "atrDone after session end", atrDone, 1'b0);
    chk("R9", "earlyFlag survives session end", earlyFlag, 1'b1);

    // R10 line low from session start is not an answer
    startSession(e0, 1'b0);
    waitEdge(e0 + WIN + 1);
    chk("R10", "cardRst rises with line held low", cardRst, 1'b1);
    chk("R10", "no flag with line held low", earlyFlag | muteFlag, 1'b0);
    ioLevel = 1'b1;
    waitEdge(e0 + WIN + 48);
    ioLevel = 1'b0;
    waitEdge(e0 + WIN + 51);
    chk("R10", "later fall accepted as answer", atrDone, 1'b1);
    chk("R10", "no flag for in-window answer", earlyFlag | muteFlag, 1'b0);
    ioLevel = 1'b1;

    // R2 count advances only on enabled cycles
    startSession(e0, 1'b1);
    hits = 0;
    for (int k = 0; k < 3*WIN; k++) begin
      clkEn = ~clkEn;
      waitEdge(edgeCnt + 1);
      if (cardRst && hits == 0) hits = edgeCnt - e0;
    end
    clkEn = 1'b1;
    chk("R2", "cardRst not early with gated clock", (hits >= 2*WIN - 2), 1'b1);
    chk("R2", "cardRst not late with gated clock", (hits <= 2*WIN + 2), 1'b1);

    sessionEn = 1'b0;
    waitEdge(edgeCnt + 2);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1'b1;
      nErr++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule